// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Registers

This block is the software-visible register file of a DRAM controller. It sits in a 4 KB window of 32-bit word registers. Word 0 holds a protection key. Word 1 is the configuration register. The remaining implemented words are plain read/write registers. Writes to every word except the key word are accepted only while the key word holds the unlock value 0xFC600309. Because the key resets to zero, the block comes out of reset locked. Firmware first writes the key, then programs the controller, and may relock by writing any other key value.

The silicon revision is chosen at elaboration by a parameter. Revision A and revision B each have their own read-only mask for the configuration register and their own reset default. Each also maps the installed memory size, given in megabytes on an input sampled during reset, to the two low configuration bits in its own way. Read-only configuration bits keep their stored value on every write. A rejected write raises an error flag for one cycle: the block is locked, the address lies outside the register array, or the access is narrower than 32 bits. Reads are combinational from the byte address. Out-of-range reads return zero.

Top module: `dram_cfg_regs`

## Requirements
- R1: While rst_n is low, the key word (byte 0x00) and every general word reset to 0. The configuration word (byte 0x04) loads its revision default: revision A gives 0x00000040 | size code, and revision B gives 0x1000000C | size code.
- R2: A write to any word other than the key word leaves that word unchanged unless the key word currently equals 0xFC600309.
- R3: The key word is always writable. It stores all 32 bits and reads them back. Any value other than 0xFC600309 locks the block.
- R4: On a configuration write, read-only bits keep their old value. For revision A these are bits 31:11, 6 and 3:2 (mask 0xFFFFF84C). For revision B these are bits 31:28, 19:14, 6 and 3:2 (mask 0xF00FC04C).
- R5: On an accepted configuration write, every bit outside the revision's read-only mask takes the written data.
- R6: Revision A size code in bits 1:0: 64 MB=0, 128 MB=1, 256 MB=2, 512 MB=3. Any other size gives 0.
- R7: Revision B size code in bits 1:0: 128 MB=0, 256 MB=1, 512 MB=2, 1024 MB=3. Any other size gives 0.
- R8: A word index (byte address >> 2) at or above NUM_REGS (default 8) reads as 0. A write to such an index changes no register.
- R9: A write whose byte enables are not all four set (be != 4'hF) changes no register, including the key word.
- R10: wr_err is high for exactly the cycle after a rejected write (locked, out of range or partial), and low after an accepted write or no write.
- R11: General words 2 to NUM_REGS-1 store all 32 written bits while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_size_mb | input | 16 | Installed memory size in MB, sampled while in reset |
| req_wr | input | 1 | Write strobe, one write per cycle |
| req_addr | input | 12 | Byte address inside the 4 KB window |
| req_be | input | 4 | Byte enables; only 4'hF is a valid write |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for req_addr |
| wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The hardest case to reach is a configuration write that is accepted and also lands on read-only bits that are not zero. Here the merge of old and new data is visible. It only happens after the key has been written, and only with data that flips the protected bits. The stimulus unlocks the block, writes all-ones and then all-zeros to the configuration word, and compares both results against a mask rebuilt in the bench. It does this for two instances, one per revision. The reset-time size codes are covered by pulsing reset once for each memory size, including one unsupported size per revision.

// File: rtl/dram_cfg_pkg.sv
package dram_cfg_pkg;

  typedef enum logic {REV_A = 1'b0, REV_B = 1'b1} rev_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned SIZE_W = 16;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

  // Bits a configuration write must not change.
  function automatic logic [DATA_W-1:0] ro_mask(rev_e r);
    return (r == REV_A) ? 32'hFFFF_F84C : 32'hF00F_C04C;
  endfunction

  // Memory size (MB) to two-bit code; unsupported sizes fall back to 0.
  function automatic logic [1:0] size_code(rev_e r, logic [SIZE_W-1:0] mb);
    logic [1:0] c;
    c = 2'd0;
    if (r == REV_A) begin
      case (mb)
        16'd128: c = 2'd1;
        16'd256: c = 2'd2;
        16'd512: c = 2'd3;
        default: c = 2'd0;
      endcase
    end else begin
      case (mb)
        16'd256:  c = 2'd1;
        16'd512:  c = 2'd2;
        16'd1024: c = 2'd3;
        default:  c = 2'd0;
      endcase
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] conf_default(rev_e r, logic [SIZE_W-1:0] mb);
    logic [DATA_W-1:0] base;
    base = (r == REV_A) ? 32'h0000_0040 : 32'h1000_000C;
    return base | {{(DATA_W-2){1'b0}}, size_code(r, mb)};
  endfunction

  function automatic logic [DATA_W-1:0] merge_write(logic [DATA_W-1:0] mask,
                                                    logic [DATA_W-1:0] old_v,
                                                    logic [DATA_W-1:0] new_v);
    return (old_v & mask) | (new_v & ~mask);
  endfunction

endpackage

// File: rtl/dram_cfg_decode.sv
module dram_cfg_decode
  import dram_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]  req_be,
  input  logic             unlocked,
  output logic [IDX_W-1:0] idx,
  output logic             in_range,
  output logic             wr_ok,
  output logic             wr_key,
  output logic             wr_conf,
  output logic             wr_err
);

  logic full_word;
  logic bad_wr;

  assign idx       = req_addr[ADDR_W-1:2];
  assign in_range  = (idx < IDX_W'(NUM_REGS));
  assign full_word = (req_be == {BE_W{1'b1}});
  assign wr_ok     = req_wr && full_word && in_range && ((idx == '0) || unlocked);
  assign wr_key    = wr_ok && (idx == IDX_W'(0));
  assign wr_conf   = wr_ok && (idx == IDX_W'(1));
  assign bad_wr    = req_wr && !wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= bad_wr;
  end

  // R8: out-of-range write must be flagged
  p_oor_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !in_range) |=> wr_err);

  // R9: partial write must be flagged
  p_partial_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_be != {BE_W{1'b1}}) |=> wr_err);

  // R10: no write means no flag
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |=> !wr_err);

endmodule

// File: rtl/dram_cfg_lock.sv
module dram_cfg_lock
  import dram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] key_q,
  output logic              unlocked
);

  always_ff @(posedge clk) begin
    if (!rst_n)      key_q <= '0;
    else if (wr_key) key_q <= wdata;
  end

  assign unlocked = (key_q == UNLOCK_KEY);

  // R3: key write always lands
  p_key_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |=> (key_q == $past(wdata)));

  // R3: key unchanged without a key write
  p_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_key |=> $stable(key_q));

endmodule

// File: rtl/dram_cfg_conf.sv
module dram_cfg_conf
  import dram_cfg_pkg::*;
#(
  parameter rev_e REV = REV_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] mem_size_mb,
  input  logic              wr_try,
  input  logic              wr_conf,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] conf_q
);

  localparam logic [DATA_W-1:0] RO = ro_mask(REV);

  always_ff @(posedge clk) begin
    if (!rst_n)       conf_q <= conf_default(REV, mem_size_mb);
    else if (wr_conf) conf_q <= merge_write(RO, conf_q, wdata);
  end

  // R2: locked attempt leaves the register untouched
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try && !unlocked) |=> $stable(conf_q));

  // R4: protected bits survive an accepted write
  p_ro_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conf |=> ((conf_q & RO) == ($past(conf_q) & RO)));

  // R5: writable bits follow the data
  p_rw_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conf |=> ((conf_q & ~RO) == ($past(wdata) & ~RO)));

endmodule

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs
  import dram_cfg_pkg::*;
#(
  parameter rev_e        REV      = REV_A,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] mem_size_mb,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_err
);

  localparam int unsigned IDX_W   = ADDR_W - 2;
  localparam int unsigned SEL_W   = $clog2(NUM_REGS);
  localparam int unsigned NUM_GEN = NUM_REGS - 2;

  logic [IDX_W-1:0]  idx;
  logic              in_range, wr_ok, wr_key, wr_conf, unlocked;
  logic [DATA_W-1:0] key_q, conf_q;
  logic [DATA_W-1:0] gen_q [NUM_GEN];
  logic [DATA_W-1:0] view  [NUM_REGS];

  dram_cfg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
    .req_be(req_be), .unlocked(unlocked), .idx(idx), .in_range(in_range),
    .wr_ok(wr_ok), .wr_key(wr_key), .wr_conf(wr_conf), .wr_err(wr_err)
  );

  dram_cfg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wdata(req_wdata),
    .key_q(key_q), .unlocked(unlocked)
  );

  dram_cfg_conf #(.REV(REV)) u_conf (
    .clk(clk), .rst_n(rst_n), .mem_size_mb(mem_size_mb),
    .wr_try(req_wr && idx == IDX_W'(1)), .wr_conf(wr_conf),
    .unlocked(unlocked), .wdata(req_wdata), .conf_q(conf_q)
  );

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NUM_GEN); i++) begin
      if (!rst_n)
        gen_q[i] <= '0;
      else if (wr_ok && idx == IDX_W'(i + 2))
        gen_q[i] <= req_wdata;
    end
  end

  assign view[0] = key_q;
  assign view[1] = conf_q;
  for (genvar g = 2; g < NUM_REGS; g++) begin : g_view
    assign view[g] = gen_q[g-2];

    // R2: general word frozen on a locked write
    p_gen_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && !unlocked) |=> $stable(gen_q[g-2]));
  end

  assign rd_data = in_range ? view[idx[SEL_W-1:0]] : '0;

endmodule

// File: tb/dram_cfg_regs_tb.sv
module dram_cfg_regs_tb_top;
  import dram_cfg_pkg::*;

  localparam logic [31:0] KEY   = 32'hFC60_0309;
  localparam logic [31:0] RO_A  = 32'hFFFF_F84C;
  localparam logic [31:0] RO_B  = 32'hF00F_C04C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] size_a = 16'd256, size_b = 16'd512;
  logic        req_wr = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        err_a, err_b;
  logic        last_err_a, last_err_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dram_cfg_regs #(.REV(REV_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_size_mb(size_a), .req_wr(req_wr),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_a), .wr_err(err_a));

  dram_cfg_regs #(.REV(REV_B)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .mem_size_mb(size_b), .req_wr(req_wr),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_b), .wr_err(err_b));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_wr = 1'b0; req_be = 4'hF;
    last_err_a = err_a; last_err_b = err_b;
  endtask

  task automatic do_read(logic [11:0] a);
    @(negedge clk);
    req_addr = a;
    #1;
  endtask

  function automatic logic [31:0] mrg(logic [31:0] m, logic [31:0] o, logic [31:0] n);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = m[b] ? o[b] : n[b];
    return r;
  endfunction

  task automatic t_reset_state();
    do_reset();
    do_read(12'h000); check("R1 key A", rd_a, 32'h0); check("R1 key B", rd_b, 32'h0);
    do_read(12'h004); check("R1 conf A 256MB", rd_a, 32'h0000_0042);
                      check("R1 conf B 512MB", rd_b, 32'h1000_000E);
    do_read(12'h008); check("R1 gen A", rd_a, 32'h0);
    check("R10 err idle", {31'b0, err_a}, 32'h0);
  endtask

  task automatic t_lock_gate();
    do_write(12'h004, 32'h0000_0000, 4'hF);
    check("R10 locked err A", {31'b0, last_err_a}, 32'h1);
    do_read(12'h004); check("R2 conf locked A", rd_a, 32'h0000_0042);
                      check("R2 conf locked B", rd_b, 32'h1000_000E);
    do_write(12'h00C, 32'hDEAD_BEEF, 4'hF);
    do_read(12'h00C); check("R2 gen locked", rd_a, 32'h0);
    do_write(12'h000, 32'h1234_5678, 4'hF);
    check("R10 key write no err", {31'b0, last_err_a}, 32'h0);
    do_read(12'h000); check("R3 key readback", rd_a, 32'h1234_5678);
    do_write(12'h004, 32'h0, 4'hF);
    do_read(12'h004); check("R2 wrong key still locked", rd_a, 32'h0000_0042);
  endtask

  task automatic t_conf_masks();
    logic [31:0] oa, ob;
    do_write(12'h000, KEY, 4'hF);
    do_read(12'h000); check("R3 unlock key", rd_b, KEY);
    oa = 32'h0000_0042; ob = 32'h1000_000E;
    do_write(12'h004, 32'hFFFF_FFFF, 4'hF);
    check("R10 accepted no err", {31'b0, last_err_a}, 32'h0);
    do_read(12'h004);
    check("R4 R5 conf ones A", rd_a, mrg(RO_A, oa, 32'hFFFF_FFFF));
    check("R4 R5 conf ones B", rd_b, mrg(RO_B, ob, 32'hFFFF_FFFF));
    oa = rd_a; ob = rd_b;
    do_write(12'h004, 32'h0, 4'hF);
    do_read(12'h004);
    check("R4 conf zeros A", rd_a, oa & RO_A);
    check("R4 conf zeros B", rd_b, ob & RO_B);
    do_write(12'h004, 32'h5A5A_5A5A, 4'hF);
    do_read(12'h004);
    check("R5 conf pattern A", rd_a, mrg(RO_A, oa & RO_A, 32'h5A5A_5A5A));
    check("R5 conf pattern B", rd_b, mrg(RO_B, ob & RO_B, 32'h5A5A_5A5A));
  endtask

  task automatic t_general();
    do_write(12'h008, 32'hA5A5_0001, 4'hF);
    do_write(12'h01C, 32'h0F0F_F0F0, 4'hF);
    do_read(12'h008); check("R11 gen word2", rd_a, 32'hA5A5_0001);
    do_read(12'h01C); check("R11 gen word7", rd_b, 32'h0F0F_F0F0);
    do_write(12'h000, 32'h0, 4'hF);
    do_write(12'h008, 32'h0, 4'hF);
    check("R10 relocked err", {31'b0, last_err_a}, 32'h1);
    do_read(12'h008); check("R3 R2 relock holds gen", rd_a, 32'hA5A5_0001);
  endtask

  task automatic t_oor_partial();
    do_write(12'h000, KEY, 4'hF);
    do_write(12'h020, 32'hFFFF_FFFF, 4'hF);
    check("R8 oor write err", {31'b0, last_err_a}, 32'h1);
    do_read(12'h020); check("R8 oor read zero", rd_a, 32'h0);
    do_read(12'hFFC); check("R8 top read zero", rd_b, 32'h0);
    do_read(12'h008); check("R8 no alias write", rd_a, 32'hA5A5_0001);
    do_write(12'h008, 32'h1111_1111, 4'h3);
    check("R9 partial err", {31'b0, last_err_b}, 32'h1);
    do_read(12'h008); check("R9 partial ignored", rd_a, 32'hA5A5_0001);
    do_write(12'h000, 32'h0, 4'h1);
    do_read(12'h000); check("R9 partial key ignored", rd_a, KEY);
    do_read(12'h000); check("R10 err one cycle", {31'b0, err_a}, 32'h0);
  endtask

  task automatic t_size_codes();
    logic [15:0] sa [5] = '{16'd64, 16'd128, 16'd256, 16'd512, 16'd100};
    logic [15:0] sb [5] = '{16'd128, 16'd256, 16'd512, 16'd1024, 16'd64};
    logic [1:0]  cc [5] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
    for (int k = 0; k < 5; k++) begin
      size_a = sa[k]; size_b = sb[k];
      do_reset();
      do_read(12'h004);
      check("R6 size code A", rd_a, 32'h0000_0040 | {30'b0, cc[k]});
      check("R7 size code B", rd_b, 32'h1000_000C | {30'b0, cc[k]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_lock_gate();
    t_conf_masks();
    t_general();
    t_oor_partial();
    t_size_codes();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule